// File: doc/BRIEF.md
# Rotating Priority Resolver with In-Service Nesting

This block picks one winner among eight interrupt request lines in a single combinational pass. A request line competes only when its mask bit is clear. Priority rotates: a 3-bit offset names the line that holds the top rank, and rank falls by one for each line after it, wrapping at the end. The unmasked request with the best rank is the candidate.

The candidate is granted only if it outranks every line already in service. This keeps higher-priority handlers nested inside lower-priority ones and never the reverse. The block can serve as the primary resolver of a cascaded pair. In that role, when the fully nested cascade option is on, the in-service bit of the cascade line (line 2) is left out of the comparison. This lets a fresh request from the secondary controller pass through while an earlier one is still being handled.

The surrounding controller owns all state: request capture, mask, in-service register, offset and mode bits. It reads the grant flag and the line number in the same cycle it drives the inputs.

Top module: `prio_resolver`

## Requirements
- R1: The pending set is the request vector with every masked line removed. A line whose mask bit is 1 never wins.
- R2: With offset k, line i has rank (i - k) mod 8, and rank 0 is the highest priority. The candidate is the pending line with the smallest rank.
- R3: When no line is pending, `grant_vld_o` is 0 and `grant_id_o` is 0.
- R4: A grant is issued only when the candidate's rank is strictly smaller than the best rank among in-service lines. An in-service line of equal or better rank blocks the grant.
- R5: When the effective in-service set is empty, any pending candidate is granted.
- R6: When `sfn_en_i` and `is_master_i` are both 1, in-service bit 2 takes no part in the comparison.
- R7: When either `sfn_en_i` or `is_master_i` is 0, in-service bit 2 blocks like any other bit.
- R8: `grant_id_o` equals (candidate rank + offset) mod 8, which is the candidate's own line number. It follows the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_i | input | 8 | Request line levels, bit i = line i |
| mask_i | input | 8 | Mask, 1 removes the line from contention |
| insvc_i | input | 8 | Lines currently in service |
| rot_ofs_i | input | 3 | Line that holds rank 0 |
| sfn_en_i | input | 1 | Fully nested cascade option |
| is_master_i | input | 1 | Resolver serves the primary controller |
| grant_vld_o | output | 1 | A line is granted |
| grant_id_o | output | 3 | Granted line number, 0 when no grant |

## Verification
The embedded immediate assertions watch four things on every evaluation:
- the granted line is pending and unmasked;
- the granted line is absent from the effective in-service set;
- the two rank scans compare strictly;
- the number output is zero whenever there is no grant.

Only the bench scenarios can show three further behaviours, checked against an independent rank model:
- the exact winner under each rotation offset;
- that equal rank blocks a grant;
- how the cascade bit behaves across the four combinations of mode and master flags.

// File: rtl/prio_pkg.sv
package prio_pkg;
  localparam int unsigned LINES      = 8;
  localparam int unsigned ID_W       = $clog2(LINES);
  localparam int unsigned CASCADE_ID = 2;
  typedef logic [LINES-1:0] line_vec_t;
  typedef logic [ID_W-1:0]  line_id_t;
endpackage

// File: rtl/rank_scan.sv
module rank_scan #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  input  logic [IW-1:0] ofs_i,
  output logic          any_o,
  output logic [IW-1:0] rank_o
);
  localparam int unsigned N_POW = 1 << IW;

  logic [N-1:0] rot;
  logic [N-1:0] hit;

  // rot[r] holds the line whose rank is r; the index wraps at IW bits
  for (genvar r = 0; r < N; r++) begin : g_rot
    localparam logic [IW-1:0] R_L = IW'(r);
    assign rot[r] = vec_i[R_L + ofs_i];
  end

  // fixed scan: rank r wins when no better rank is set
  for (genvar r = 0; r < N; r++) begin : g_hit
    if (r == 0) begin : g_top
      assign hit[r] = rot[r];
    end else begin : g_rest
      assign hit[r] = rot[r] & ~(|rot[r-1:0]);
    end
  end

  always_comb begin
    rank_o = '0;
    for (int r = 0; r < N; r++) begin
      rank_o = rank_o | (hit[r] ? IW'(r) : '0);
    end
  end

  assign any_o = |vec_i;

  always_comb begin
    if (N_POW != N) $error("rank_scan needs a power-of-two line count");
    assert ($countones(hit) == (any_o ? 1 : 0))
      else $error("p_one_winner_r2 violated");
  end
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
  import prio_pkg::*;
(
  input  logic [7:0] req_i,
  input  logic [7:0] mask_i,
  input  logic [7:0] insvc_i,
  input  logic [2:0] rot_ofs_i,
  input  logic       sfn_en_i,
  input  logic       is_master_i,
  output logic       grant_vld_o,
  output logic [2:0] grant_id_o
);
  line_vec_t pend;
  line_vec_t isr_eff;
  logic      pend_any, isr_any;
  line_id_t  pend_rank, isr_rank;
  logic [ID_W:0] pend_rank_x, isr_rank_x;

  assign pend = req_i & ~mask_i;

  always_comb begin
    isr_eff = insvc_i;
    if (sfn_en_i && is_master_i) isr_eff[CASCADE_ID] = 1'b0;
  end

  rank_scan #(.N(LINES), .IW(ID_W)) u_pend_scan (
    .vec_i (pend),
    .ofs_i (rot_ofs_i),
    .any_o (pend_any),
    .rank_o(pend_rank)
  );

  rank_scan #(.N(LINES), .IW(ID_W)) u_isr_scan (
    .vec_i (isr_eff),
    .ofs_i (rot_ofs_i),
    .any_o (isr_any),
    .rank_o(isr_rank)
  );

  // an empty vector ranks one below the lowest line
  assign pend_rank_x = pend_any ? {1'b0, pend_rank} : (ID_W+1)'(LINES);
  assign isr_rank_x  = isr_any  ? {1'b0, isr_rank}  : (ID_W+1)'(LINES);

  assign grant_vld_o = pend_rank_x < isr_rank_x;
  assign grant_id_o  = grant_vld_o ? line_id_t'(pend_rank + rot_ofs_i) : '0;

  always_comb begin
    assert (!grant_vld_o || pend[grant_id_o])
      else $error("p_grant_pending_r1 violated");
    assert (!grant_vld_o || !isr_eff[grant_id_o])
      else $error("p_not_in_service_r4 violated");
    assert (grant_vld_o || grant_id_o == '0)
      else $error("p_idle_zero_r3 violated");
    assert (!grant_vld_o || !isr_any || pend_rank < isr_rank)
      else $error("p_strict_rank_r4 violated");
    assert (pend_any || !grant_vld_o)
      else $error("p_no_pend_no_grant_r3 violated");
  end
endmodule

// File: tb/prio_resolver_bench.sv
module prio_resolver_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req, mask, insvc;
  logic [2:0] ofs;
  logic       sfn, mst;
  logic       vld;
  logic [2:0] gid;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prio_resolver u_prio_resolver (
    .req_i(req), .mask_i(mask), .insvc_i(insvc), .rot_ofs_i(ofs),
    .sfn_en_i(sfn), .is_master_i(mst), .grant_vld_o(vld), .grant_id_o(gid)
  );

  function automatic logic [3:0] model(logic [7:0] rq, logic [7:0] mk,
      logic [7:0] is, logic [2:0] k, logic sf, logic ms);
    logic [7:0] p;
    logic [7:0] s;
    int pr;
    int sr;
    p = rq & ~mk;
    s = is;
    if (sf && ms) s[2] = 1'b0;
    pr = 8;
    sr = 8;
    for (int r = 7; r >= 0; r--) begin
      if (p[(r + k) % 8]) pr = r;
      if (s[(r + k) % 8]) sr = r;
    end
    if (pr < sr) return {1'b1, 3'((pr + k) % 8)};
    return 4'b0000;
  endfunction

  task automatic apply(logic [7:0] rq, logic [7:0] mk, logic [7:0] is,
      logic [2:0] k, logic sf, logic ms, string tag);
    logic [3:0] exp;
    @(posedge clk);
    req = rq; mask = mk; insvc = is; ofs = k; sfn = sf; mst = ms;
    @(negedge clk);
    exp = model(rq, mk, is, k, sf, ms);
    n_chk++;
    if ({vld, gid} !== exp) begin
      n_bad++;
      $display("FAIL %s: got vld=%0b id=%0d, expected vld=%0b id=%0d",
               tag, vld, gid, exp[3], exp[2:0]);
    end
  endtask

  task automatic expect_out(logic ev, logic [2:0] eid, string tag);
    n_chk++;
    if (vld !== ev || gid !== eid) begin
      n_bad++;
      $display("FAIL %s: got vld=%0b id=%0d, expected vld=%0b id=%0d",
               tag, vld, gid, ev, eid);
    end
  endtask

  initial begin
    #3000000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    req = '0; mask = '0; insvc = '0; ofs = '0; sfn = 0; mst = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out(1'b0, 3'd0, "R3 reset idle");
    apply(8'h10, 8'h10, 8'h00, 3'd0, 0, 0, "R1");
    expect_out(1'b0, 3'd0, "R1 masked line");
    apply(8'h81, 8'h00, 8'h00, 3'd0, 0, 0, "R2");
    expect_out(1'b1, 3'd0, "R2 offset 0");
    apply(8'h81, 8'h00, 8'h00, 3'd1, 0, 0, "R2");
    expect_out(1'b1, 3'd7, "R2 offset 1");
    apply(8'h08, 8'h00, 8'h08, 3'd0, 0, 0, "R4");
    expect_out(1'b0, 3'd0, "R4 equal rank");
    apply(8'h08, 8'h00, 8'h04, 3'd0, 0, 0, "R4");
    expect_out(1'b0, 3'd0, "R4 better in service");
    apply(8'h08, 8'h00, 8'h10, 3'd0, 0, 0, "R4");
    expect_out(1'b1, 3'd3, "R4 beats in service");
    apply(8'h80, 8'h00, 8'h00, 3'd0, 0, 0, "R5");
    expect_out(1'b1, 3'd7, "R5 empty in service");
    apply(8'h01, 8'h00, 8'h04, 3'd1, 1, 1, "R6");
    expect_out(1'b1, 3'd0, "R6 cascade bit ignored");
    apply(8'h01, 8'h00, 8'h04, 3'd1, 1, 0, "R7");
    expect_out(1'b0, 3'd0, "R7 not master");
    apply(8'h01, 8'h00, 8'h04, 3'd1, 0, 1, "R7");
    expect_out(1'b0, 3'd0, "R7 mode off");
    apply(8'h20, 8'h00, 8'h00, 3'd5, 0, 0, "R8");
    expect_out(1'b1, 3'd5, "R8 id from rank");
    apply(8'hff, 8'hff, 8'h00, 3'd3, 1, 1, "R3");
    expect_out(1'b0, 3'd0, "R3 all masked");
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    for (int i = 0; i < 3000; i++) begin
      apply(8'($urandom), 8'($urandom) & 8'($urandom), 8'($urandom) & 8'($urandom),
            3'($urandom), 1'($urandom), 1'($urandom), "R8 random");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule